// File: doc/BRIEF.md
# Keyed Mode-Register Write Sequencer

This block protects a single operating-mode bit that chooses between normal operation and flash self-programming. Software cannot set the bit with one store. It must first write a key byte to a command register, then write the new mode value to the mode register three times: the value, its bitwise complement, and the value again. The bit changes only when the last of those writes arrives intact. Any departure from that order is dropped, and it also raises a sticky fault flag. Software polls the flag, retries the whole series while it reads 1, and clears it by writing zero to the status register.

The block watches a single-cycle register write bus made of an address, a data byte and a strobe. It drives the committed mode as a level output and also as a read-back value. Read data is combinational from a separate read address. The fault flag appears both as a port and as bit 0 of the status register.

Top module: `mode_key_guard`

## Requirements
- R1: After a synchronous reset the mode is normal (0), the fault flag is clear and the checker is idle, so a following mode-register write with no key counts as an unkeyed write.
- R2: A write of 0xA5 to the key register (address 0x20), followed by three writes to the mode register (address 0x21), commits the mode on the clock edge that takes the third write. The mode output does not change after the key write or after the first or second value write.
- R3: The series 0x01, 0xFE, 0x01 selects self-programming mode (mode bit 1). The series 0x00, 0xFF, 0x00 selects normal mode (mode bit 0). Only bit 0 of the value carries the mode.
- R4: A broken value series drops the sequence, sets the fault flag and leaves the mode unchanged. A series is broken if its first value has any bit other than bit 0 set, if its second value is not the exact complement of the first, or if its third value differs from the first.
- R5: A mode-register write while no key is pending sets the fault flag and leaves the mode unchanged.
- R6: A key-register write with any data other than 0xA5 sets the fault flag and leaves the checker idle.
- R7: While a sequence is pending, a write to any address other than the key or mode register drops the sequence and sets the fault flag. While the checker is idle, writes to such addresses have no effect on mode or fault.
- R8: A write of 0xA5 to the key register while a sequence is pending restarts the sequence at its first value step, with no fault.
- R9: The fault flag stays set, even across later successful sequences, until a write of 0x00 to the status register (address 0x22) while idle clears it. A write of any other value to the status register leaves the flag set.
- R10: Reading the mode register returns the committed mode in bit 0, never a pending value. Reading the status register returns the fault flag in bit 0. All other read addresses return 0, and every unused bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| mode_prog | output | 1 | Committed mode: 1 self-programming, 0 normal |
| fault | output | 1 | Sticky sequence fault flag |

## Verification
Every write takes effect on the rising edge that samples its strobe. The mode and fault outputs are therefore due one edge after the write, and read data follows them in the same cycle with no added latency. The bench drives each write on a falling edge and samples on the next falling edge, which lies half a period after the edge that updates the state. For each write it compares the port values and both read-back registers with the values expected for that step. This catches an early commit or a fault raised a step late as a mismatch in the exact cycle it occurs.

// File: rtl/mkg_pkg.sv
// Package: shared state encoding for the keyed mode-write sequencer.
// Assumes a single write per clock cycle on the observed bus.
package mkg_pkg;

    // Progress of the keyed series: idle, key seen, value seen, complement seen.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_VAL   = 2'd2,
        SEQ_INV   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/mkg_step_check.sv
// Module: mkg_step_check
// Follows the key / value / complement / value series on the write bus.
// Emits a one-cycle commit strobe with the committed bit, or a one-cycle
// abort strobe whenever the series is broken. Assumes one write per cycle.
module mkg_step_check
    import mkg_pkg::*;
#(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   KEY_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0]   MODE_ADDR = 8'h21,
    parameter logic [DATA_W-1:0]   KEY_VAL   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              commit_stb,
    output logic              commit_bit,
    output logic              abort_stb
);

    seq_state_t        state_q, state_d;
    logic [DATA_W-1:0] held_q, held_d;
    logic              hit_key, hit_mode, val_legal;

    // Decode which register the current write targets.
    always_comb begin
        hit_key   = wr_en && (wr_addr == KEY_ADDR);
        hit_mode  = wr_en && (wr_addr == MODE_ADDR);
        val_legal = (wr_data[DATA_W-1:1] == '0);
    end

    // Next-state and strobe logic for the keyed series.
    always_comb begin
        state_d    = state_q;
        held_d     = held_q;
        commit_stb = 1'b0;
        abort_stb  = 1'b0;
        if (hit_key) begin
            if (wr_data == KEY_VAL) begin
                state_d = SEQ_ARMED;
            end else begin
                abort_stb = 1'b1;
                state_d   = SEQ_IDLE;
            end
        end else if (hit_mode) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    abort_stb = 1'b1;
                end
                SEQ_ARMED: begin
                    if (val_legal) begin
                        held_d  = wr_data;
                        state_d = SEQ_VAL;
                    end else begin
                        abort_stb = 1'b1;
                        state_d   = SEQ_IDLE;
                    end
                end
                SEQ_VAL: begin
                    if (wr_data == ~held_q) begin
                        state_d = SEQ_INV;
                    end else begin
                        abort_stb = 1'b1;
                        state_d   = SEQ_IDLE;
                    end
                end
                SEQ_INV: begin
                    state_d = SEQ_IDLE;
                    if (wr_data == held_q) begin
                        commit_stb = 1'b1;
                    end else begin
                        abort_stb = 1'b1;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end else if (wr_en && (state_q != SEQ_IDLE)) begin
            abort_stb = 1'b1;
            state_d   = SEQ_IDLE;
        end
    end

    // State and held-value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Expose progress and the bit to be committed.
    always_comb begin
        busy       = (state_q != SEQ_IDLE);
        commit_bit = held_q[0];
    end

endmodule

// File: rtl/mkg_flags.sv
// Module: mkg_flags
// Holds the committed mode bit and the sticky fault flag.
// Assumes commit and abort strobes are never high together.
module mkg_flags #(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   STAT_ADDR = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_stb,
    input  logic              commit_bit,
    input  logic              abort_stb,
    output logic              mode_q,
    output logic              fault_q
);

    logic clear_req;

    // A zero written to the status register requests a fault clear.
    always_comb clear_req = wr_en && (wr_addr == STAT_ADDR) && (wr_data == '0);

    // Mode bit: loads only on a completed series.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= 1'b0;
        else if (commit_stb) mode_q <= commit_bit;
    end

    // Fault flag: set by any abort, which wins over a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_q <= 1'b0;
        else if (abort_stb) fault_q <= 1'b1;
        else if (clear_req) fault_q <= 1'b0;
    end

endmodule

// File: rtl/mkg_read_mux.sv
// Module: mkg_read_mux
// Combinational read-back of the mode and status registers.
// Assumes unused bits and unmapped addresses read as zero.
module mkg_read_mux #(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   MODE_ADDR = 8'h21,
    parameter logic [ADDR_W-1:0]   STAT_ADDR = 8'h22
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              mode_q,
    input  logic              fault_q,
    output logic [DATA_W-1:0] rd_data
);

    // Select the register addressed by rd_addr.
    always_comb begin
        rd_data = '0;
        if (rd_addr == MODE_ADDR)      rd_data[0] = mode_q;
        else if (rd_addr == STAT_ADDR) rd_data[0] = fault_q;
    end

endmodule

// File: rtl/mode_key_guard.sv
// Module: mode_key_guard (top)
// Guards the one-bit operating-mode register behind a key write and a
// value / complement / value series, with a sticky fault flag.
// Assumes a single-cycle write bus and a synchronous active-low reset.
module mode_key_guard #(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   KEY_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0]   MODE_ADDR = 8'h21,
    parameter logic [ADDR_W-1:0]   STAT_ADDR = 8'h22,
    parameter logic [DATA_W-1:0]   KEY_VAL   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mode_prog,
    output logic              fault
);

    logic seq_busy, commit_stb, commit_bit, abort_stb;
    logic mode_q, fault_q;

    mkg_step_check #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEY_ADDR(KEY_ADDR), .MODE_ADDR(MODE_ADDR), .KEY_VAL(KEY_VAL)
    ) i_step (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(seq_busy), .commit_stb(commit_stb),
        .commit_bit(commit_bit), .abort_stb(abort_stb)
    );

    mkg_flags #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
    ) i_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_stb(commit_stb), .commit_bit(commit_bit),
        .abort_stb(abort_stb), .mode_q(mode_q), .fault_q(fault_q)
    );

    mkg_read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)
    ) i_rd (
        .rd_addr(rd_addr), .mode_q(mode_q), .fault_q(fault_q), .rd_data(rd_data)
    );

    // Drive the level outputs from the flag registers.
    always_comb begin
        mode_prog = mode_q;
        fault     = fault_q;
    end

endmodule

// File: rtl/mkg_checker.sv
// Module: mkg_checker
// Temporal checks on the keyed mode-write sequencer, bound to the top.
// Assumes the sequence-pending signal of the step checker is connected.
module mkg_checker #(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   KEY_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0]   MODE_ADDR = 8'h21,
    parameter logic [ADDR_W-1:0]   STAT_ADDR = 8'h22,
    parameter logic [DATA_W-1:0]   KEY_VAL   = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              mode_prog,
    input logic              fault,
    input logic              busy
);

    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (!mode_prog && !fault && !busy)); // R1

    AST_MODE_ONLY_BY_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_prog) && $past(rst_n)) |-> $past(wr_en && wr_addr == MODE_ADDR && busy)); // R2

    AST_UNKEYED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MODE_ADDR && !busy) |=> (fault && $stable(mode_prog))); // R5

    AST_BAD_KEY_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR && wr_data != KEY_VAL) |=> (fault && !busy)); // R6

    AST_FOREIGN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr != KEY_ADDR && wr_addr != MODE_ADDR) |=> (fault && !busy)); // R7

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR && wr_data == KEY_VAL) |=> busy); // R8

    AST_FAULT_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fault) && $past(rst_n)) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data == '0)); // R9

endmodule

bind mode_key_guard mkg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR), .KEY_VAL(KEY_VAL)
) i_mkg_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_prog(mode_prog), .fault(fault), .busy(seq_busy)
);

// File: tb/test_mode_key_guard.sv
`timescale 1ns/1ps
module test_mode_key_guard;

    localparam logic [7:0] KA = 8'h20;
    localparam logic [7:0] MA = 8'h21;
    localparam logic [7:0] SA = 8'h22;
    localparam logic [7:0] XA = 8'h30;
    localparam int NV = 40;

    // Vector fields: {addr, data, expected mode, expected fault, requirement}
    localparam logic [25:0] VEC [NV] = '{
        {KA, 8'hA5, 1'b0, 1'b0, 8'd2},  // R2 key alone
        {MA, 8'h01, 1'b0, 1'b0, 8'd2},  // R2 first value
        {MA, 8'hFE, 1'b0, 1'b0, 8'd10}, // R10 pending not visible
        {MA, 8'h01, 1'b1, 1'b0, 8'd3},  // R3 self-programming
        {KA, 8'hA5, 1'b1, 1'b0, 8'd2},
        {MA, 8'h00, 1'b1, 1'b0, 8'd2},
        {MA, 8'hFF, 1'b1, 1'b0, 8'd2},
        {MA, 8'h00, 1'b0, 1'b0, 8'd3},  // R3 normal
        {MA, 8'h01, 1'b0, 1'b1, 8'd5},  // R5 unkeyed
        {SA, 8'h00, 1'b0, 1'b0, 8'd9},  // R9 clear
        {KA, 8'hA5, 1'b0, 1'b0, 8'd2},
        {MA, 8'h01, 1'b0, 1'b0, 8'd2},
        {MA, 8'h01, 1'b0, 1'b1, 8'd4},  // R4 not complement
        {SA, 8'h00, 1'b0, 1'b0, 8'd9},
        {KA, 8'h5A, 1'b0, 1'b1, 8'd6},  // R6 bad key
        {SA, 8'h00, 1'b0, 1'b0, 8'd9},
        {KA, 8'hA5, 1'b0, 1'b0, 8'd2},
        {MA, 8'h01, 1'b0, 1'b0, 8'd2},
        {XA, 8'h00, 1'b0, 1'b1, 8'd7},  // R7 foreign write aborts
        {SA, 8'h00, 1'b0, 1'b0, 8'd9},
        {XA, 8'hFF, 1'b0, 1'b0, 8'd7},  // R7 ignored while idle
        {KA, 8'hA5, 1'b0, 1'b0, 8'd8},
        {MA, 8'h01, 1'b0, 1'b0, 8'd8},
        {KA, 8'hA5, 1'b0, 1'b0, 8'd8},  // R8 restart
        {MA, 8'h01, 1'b0, 1'b0, 8'd8},
        {MA, 8'hFE, 1'b0, 1'b0, 8'd8},
        {MA, 8'h01, 1'b1, 1'b0, 8'd8},  // R8 commit after restart
        {KA, 8'hA5, 1'b1, 1'b0, 8'd4},
        {MA, 8'h00, 1'b1, 1'b0, 8'd4},
        {MA, 8'hFF, 1'b1, 1'b0, 8'd4},
        {MA, 8'h01, 1'b1, 1'b1, 8'd4},  // R4 repeat mismatch
        {SA, 8'h07, 1'b1, 1'b1, 8'd9},  // R9 nonzero status write
        {KA, 8'hA5, 1'b1, 1'b1, 8'd9},
        {MA, 8'h00, 1'b1, 1'b1, 8'd9},
        {MA, 8'hFF, 1'b1, 1'b1, 8'd9},
        {MA, 8'h00, 1'b0, 1'b1, 8'd9},  // R9 sticky across success
        {SA, 8'h00, 1'b0, 1'b0, 8'd9},
        {KA, 8'hA5, 1'b0, 1'b0, 8'd4},
        {MA, 8'h02, 1'b0, 1'b1, 8'd4},  // R4 illegal value
        {SA, 8'h00, 1'b0, 1'b0, 8'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       mode_prog, fault;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    mode_key_guard i_mode_key_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mode_prog(mode_prog), .fault(fault)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare ports and both read-back registers; called at a falling edge.
    task automatic check_all(input int req, input logic em, input logic ef);
        check(req, "mode port", {7'b0, mode_prog}, {7'b0, em});
        check(req, "fault port", {7'b0, fault}, {7'b0, ef});
        rd_addr = MA; #0.1;
        check(req, "mode readback", rd_data, {7'b0, em});
        rd_addr = SA; #0.1;
        check(req, "status readback", rd_data, {7'b0, ef});
    endtask

    // One write: driven at a falling edge, taken at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all(1, 1'b0, 1'b0); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][25:18], VEC[i][17:10]);
            check_all(int'(VEC[i][7:0]), VEC[i][9], VEC[i][8]);
        end

        // R10: unmapped read address returns zero
        rd_addr = XA; #0.1;
        check(10, "unmapped read", rd_data, 8'h00);

        // R1: reset mid-sequence drops the pending series and clears the mode
        wr(KA, 8'hA5); wr(MA, 8'h01); wr(MA, 8'hFE); wr(MA, 8'h01);
        check_all(3, 1'b1, 1'b0); // R3
        wr(KA, 8'hA5); wr(MA, 8'h00);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all(1, 1'b0, 1'b0); // R1 reset clears mode
        wr(MA, 8'hFF);
        check_all(1, 1'b0, 1'b1); // R1 idle after reset: unkeyed write faults

        // R9: status clear during a pending series is an abort, not a clear
        wr(SA, 8'h00);
        wr(KA, 8'hA5); wr(SA, 8'h00);
        check_all(9, 1'b0, 1'b1); // R9 / R7

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule